// File: doc/BRIEF.md
# Pixel Cluster Finder

This block groups pixel hits into clusters. Hits arrive one per handshake as a column and row pair, sorted by column. Each module of hits ends with a marker word. The block picks a reference hit and opens a small grid around it. The grid spans a fixed number of columns, starting at the reference column with its lowest bit cleared, and a fixed number of rows centred on the reference row. Every hit that falls inside the grid is loaded into it.

Two seed cells on the middle row are marked. The mark then spreads one step per cycle to occupied neighbouring cells. While it spreads, marked hits are sent out one per cycle, in coordinates relative to the grid. When the mark stops spreading, an end-of-cluster word carries the reference hit's absolute position. Occupied cells that were not marked go into a circular buffer in absolute coordinates, and they are taken up again for later clusters. When the marker word arrives and the buffer is empty, the block emits an end-of-module word.

A typical use is data reduction ahead of a centroid stage. Each cluster arrives there as a closed group of words.

Top module: `pixel_cluster_finder`

## Requirements
- R1: After reset no output word is valid, and `in_ready` is low while `in_valid` is low.
- R2: With MID = GRID_ROWS/2 and base = reference column with bit 0 cleared, each output hit word holds local column = hit column − base in `out_col` and local row = hit row − reference row + MID in `out_row`. The reference hit itself therefore sits at local (reference column bit 0, MID).
- R3: A cluster holds the occupied grid cells that are 8-connected (sideways, vertically or diagonally) to an occupied seed cell. The seed cells are local (0, MID) and (1, MID). Each hit of the cluster is output exactly once before the end-of-cluster word.
- R4: Only hits whose local column lies in 0..GRID_COLS−1 and whose local row lies in 0..GRID_ROWS−1 enter the grid. The first input hit whose column lies past the grid is left unaccepted and is handled in a later cluster.
- R5: Hit words have `out_kind` = 0. The end-of-cluster word has `out_kind` = 1 and carries the reference hit's absolute column and row.
- R6: The next reference hit is the oldest buffered hit. Input is used only when the buffer is empty. Unclaimed grid cells are written to the buffer in ascending local column, then ascending local row. Buffered hits that miss the new grid keep their relative order.
- R7: When the end-of-module marker is at the input and the buffer is empty, one word with `out_kind` = 2 is emitted and the marker is consumed. A module with no hits yields only this word.
- R8: While `out_valid` is high and `out_ready` is low, the output word does not change.
- R9: Every input hit appears in exactly one cluster. The buffer never holds more than BUF_DEPTH hits.
- R10: `in_ready` is high only while `in_valid` is high. No input is accepted while a cluster is growing or being flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle |
| in_eom | input | 1 | Input word is the end-of-module marker |
| in_col | input | COL_W | Hit column |
| in_row | input | ROW_W | Hit row |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_kind | output | 2 | 0 hit, 1 end of cluster, 2 end of module |
| out_col | output | COL_W | Local column (hit) or absolute reference column |
| out_row | output | ROW_W | Local row (hit) or absolute reference row |

## Verification
The assertions assume that no two hits of a module share a cell, that hits come in non-decreasing column order, and that no module holds more hits than the buffer can keep. A duplicate would be loaded into an occupied cell, and an oversized module would overflow the buffer. Every stimulus module is built from a set of unique cells sorted by column, and the largest has 40 hits against a 64-entry buffer. Gaps in input validity and a stalling output ready are mixed in, so the hold rule and the input-acceptance rule are both exercised.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic [1:0] {
    WORD_HIT = 2'd0,
    WORD_EOC = 2'd1,
    WORD_EOM = 2'd2
  } word_kind_e;

  typedef enum logic [2:0] {
    ST_PICK,
    ST_DRAIN,
    ST_FILL,
    ST_GROW,
    ST_FLUSH
  } fsm_e;
endpackage

// File: rtl/pcf_ring.sv
module pcf_ring #(
  parameter int W     = 17,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CW'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/pcf_grid.sv
module pcf_grid #(
  parameter int GC       = 8,
  parameter int GR       = 21,
  parameter int SEED_ROW = 10,
  localparam int CI_W    = $clog2(GC),
  localparam int RI_W    = $clog2(GR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [CI_W-1:0] load_c,
  input  logic [RI_W-1:0] load_r,
  input  logic            seed_en,
  input  logic            grow_en,
  input  logic            take_en,
  input  logic [CI_W-1:0] take_c,
  input  logic [RI_W-1:0] take_r,
  output logic            pend_any,
  output logic [CI_W-1:0] pend_c,
  output logic [RI_W-1:0] pend_r,
  output logic            occ_any,
  output logic [CI_W-1:0] occ_c,
  output logic [RI_W-1:0] occ_r,
  output logic            front_any
);
  logic [GC-1:0][GR-1:0]     occ, sel, near, front, pend, seeds;
  logic [GC+1:0][GR+1:0]     padded;

  always_comb begin
    padded = '0;
    seeds  = '0;
    seeds[0][SEED_ROW] = 1'b1;
    seeds[1][SEED_ROW] = 1'b1;
    for (int c = 0; c < GC; c++)
      for (int r = 0; r < GR; r++)
        padded[c+1][r+1] = sel[c][r];
  end

  // 3x3 neighbourhood around each cell (self included; masked by ~sel below)
  for (genvar gc = 0; gc < GC; gc++) begin : g_col
    for (genvar gr = 0; gr < GR; gr++) begin : g_row
      assign near[gc][gr] = |{padded[gc][gr+2:gr], padded[gc+1][gr+2:gr],
                              padded[gc+2][gr+2:gr]};
    end
  end

  assign front     = occ & ~sel & near;
  assign pend      = occ & sel;
  assign front_any = |front;
  assign pend_any  = |pend;
  assign occ_any   = |occ;

  // lowest column first, then lowest row
  always_comb begin
    pend_c = '0; pend_r = '0; occ_c = '0; occ_r = '0;
    for (int c = GC - 1; c >= 0; c--)
      for (int r = GR - 1; r >= 0; r--) begin
        if (pend[c][r]) begin pend_c = CI_W'(c); pend_r = RI_W'(r); end
        if (occ[c][r])  begin occ_c  = CI_W'(c); occ_r  = RI_W'(r); end
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
      sel <= '0;
    end else begin
      if (seed_en)      sel <= seeds & occ;
      else if (grow_en) sel <= sel | front;
      if (load_en) occ[load_c][load_r] <= 1'b1;
      if (take_en) occ[take_c][take_r] <= 1'b0;
    end
  end

  assert_load_free_R9: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !occ[load_c][load_r]);
  assert_take_held_R9: assert property (@(posedge clk) disable iff (rst)
    take_en |-> occ[take_c][take_r]);
  assert_load_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (int'(load_c) < GC && int'(load_r) < GR));
endmodule

// File: rtl/pixel_cluster_finder.sv
module pixel_cluster_finder
  import pcf_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int ROW_W     = 9,
  parameter int GRID_COLS = 8,
  parameter int GRID_ROWS = 21,
  parameter int BUF_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_eom,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROW_W-1:0] in_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [COL_W-1:0] out_col,
  output logic [ROW_W-1:0] out_row
);
  localparam int CI_W  = $clog2(GRID_COLS);
  localparam int RI_W  = $clog2(GRID_ROWS);
  localparam int MID   = GRID_ROWS / 2;
  localparam int HW    = COL_W + ROW_W;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  typedef struct packed {
    logic            col_ok;
    logic            row_ok;
    logic [CI_W-1:0] lc;
    logic [RI_W-1:0] lr;
  } place_t;

  fsm_e             state, state_nx;
  logic [COL_W-1:0] ref_col, base;
  logic [ROW_W-1:0] ref_row;
  logic [CNT_W-1:0] drain_left;

  logic            ring_push, ring_pop, ring_empty;
  logic [HW-1:0]   ring_head, push_data;
  logic [CNT_W-1:0] ring_count;

  logic            load_en, seed_en, grow_en, take_en;
  logic [CI_W-1:0] load_c, take_c, pend_c, occ_c;
  logic [RI_W-1:0] load_r, take_r, pend_r, occ_r;
  logic            pend_any, occ_any, front_any;

  logic            slot_free, emit_hit, emit_eoc, emit_eom, take_ref;
  place_t          head_pl, in_pl;

  function automatic place_t locate(input logic [COL_W-1:0] col, input logic [ROW_W-1:0] row,
                                    input logic [COL_W-1:0] b, input logic [ROW_W-1:0] rr);
    place_t                  p;
    logic [COL_W:0]          dc;
    logic signed [ROW_W+1:0] dr;
    dc = {1'b0, col} - {1'b0, b};
    dr = $signed({2'b00, row}) - $signed({2'b00, rr}) + $signed((ROW_W+2)'(MID));
    p.col_ok = (dc < (COL_W+1)'(GRID_COLS));
    p.row_ok = (dr >= 0) && (dr < $signed((ROW_W+2)'(GRID_ROWS)));
    p.lc     = dc[CI_W-1:0];
    p.lr     = dr[RI_W-1:0];
    return p;
  endfunction

  assign base      = {ref_col[COL_W-1:1], 1'b0};
  assign head_pl   = locate(ring_head[HW-1:ROW_W], ring_head[ROW_W-1:0], base, ref_row);
  assign in_pl     = locate(in_col, in_row, base, ref_row);
  assign slot_free = !out_valid || out_ready;

  always_comb begin
    state_nx  = state;
    in_ready  = 1'b0;
    ring_push = 1'b0;
    ring_pop  = 1'b0;
    push_data = ring_head;
    load_en   = 1'b0;
    load_c    = '0;
    load_r    = '0;
    seed_en   = 1'b0;
    grow_en   = 1'b0;
    take_en   = 1'b0;
    take_c    = pend_c;
    take_r    = pend_r;
    emit_hit  = 1'b0;
    emit_eoc  = 1'b0;
    emit_eom  = 1'b0;
    take_ref  = 1'b0;
    case (state)
      ST_PICK: begin
        load_r = RI_W'(MID);
        if (!ring_empty) begin
          ring_pop = 1'b1;
          load_en  = 1'b1;
          load_c   = CI_W'(ring_head[ROW_W]);
          take_ref = 1'b1;
          state_nx = (ring_count == CNT_W'(1)) ? ST_FILL : ST_DRAIN;
        end else if (in_valid && !in_eom) begin
          in_ready = 1'b1;
          load_en  = 1'b1;
          load_c   = CI_W'(in_col[0]);
          take_ref = 1'b1;
          state_nx = ST_FILL;
        end else if (in_valid && in_eom && slot_free) begin
          in_ready = 1'b1;
          emit_eom = 1'b1;
        end
      end
      ST_DRAIN: begin
        ring_pop = 1'b1;
        if (head_pl.col_ok && head_pl.row_ok) begin
          load_en = 1'b1;
          load_c  = head_pl.lc;
          load_r  = head_pl.lr;
        end else begin
          ring_push = 1'b1;
        end
        if (drain_left == CNT_W'(1)) state_nx = ST_FILL;
      end
      ST_FILL: begin
        if (in_valid && !in_eom && in_pl.col_ok) begin
          in_ready = 1'b1;
          if (in_pl.row_ok) begin
            load_en = 1'b1;
            load_c  = in_pl.lc;
            load_r  = in_pl.lr;
          end else begin
            ring_push = 1'b1;
            push_data = {in_col, in_row};
          end
        end else if (in_valid) begin
          seed_en  = 1'b1;
          state_nx = ST_GROW;
        end
      end
      ST_GROW: begin
        grow_en = 1'b1;
        if (slot_free) begin
          if (pend_any) begin
            take_en  = 1'b1;
            emit_hit = 1'b1;
          end else if (!front_any) begin
            emit_eoc = 1'b1;
            state_nx = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        take_c = occ_c;
        take_r = occ_r;
        if (occ_any) begin
          take_en   = 1'b1;
          ring_push = 1'b1;
          push_data = {base + COL_W'(occ_c), ref_row + ROW_W'(occ_r) - ROW_W'(MID)};
        end else begin
          state_nx = ST_PICK;
        end
      end
      default: state_nx = ST_PICK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PICK;
      ref_col    <= '0;
      ref_row    <= '0;
      drain_left <= '0;
      out_valid  <= 1'b0;
      out_kind   <= WORD_HIT;
      out_col    <= '0;
      out_row    <= '0;
    end else begin
      state <= state_nx;
      if (take_ref) begin
        if (!ring_empty) begin
          ref_col    <= ring_head[HW-1:ROW_W];
          ref_row    <= ring_head[ROW_W-1:0];
          drain_left <= ring_count - 1'b1;
        end else begin
          ref_col <= in_col;
          ref_row <= in_row;
        end
      end else if (state == ST_DRAIN) begin
        drain_left <= drain_left - 1'b1;
      end
      if (emit_hit) begin
        out_valid <= 1'b1;
        out_kind  <= WORD_HIT;
        out_col   <= COL_W'(pend_c);
        out_row   <= ROW_W'(pend_r);
      end else if (emit_eoc) begin
        out_valid <= 1'b1;
        out_kind  <= WORD_EOC;
        out_col   <= ref_col;
        out_row   <= ref_row;
      end else if (emit_eom) begin
        out_valid <= 1'b1;
        out_kind  <= WORD_EOM;
        out_col   <= '0;
        out_row   <= '0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  pcf_ring #(.W(HW), .DEPTH(BUF_DEPTH)) u_ring (
    .clk(clk), .rst(rst), .push(ring_push), .push_data(push_data), .pop(ring_pop),
    .head(ring_head), .empty(ring_empty), .count(ring_count)
  );

  pcf_grid #(.GC(GRID_COLS), .GR(GRID_ROWS), .SEED_ROW(MID)) u_grid (
    .clk(clk), .rst(rst), .load_en(load_en), .load_c(load_c), .load_r(load_r),
    .seed_en(seed_en), .grow_en(grow_en), .take_en(take_en), .take_c(take_c),
    .take_r(take_r), .pend_any(pend_any), .pend_c(pend_c), .pend_r(pend_r),
    .occ_any(occ_any), .occ_c(occ_c), .occ_r(occ_r), .front_any(front_any)
  );

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_col)
                                   && $stable(out_row)));
  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> in_valid);
  assert_quiet_input_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GROW || state == ST_FLUSH) |-> !in_ready);
  assert_hit_local_range_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == WORD_HIT) |->
      (int'(out_col) < GRID_COLS && int'(out_row) < GRID_ROWS));
  assert_kind_legal_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_kind != 2'd3));
endmodule

// File: tb/pixel_cluster_finder_bench.sv
`timescale 1ns/1ps
module pixel_cluster_finder_bench;
  localparam int GC  = 8;
  localparam int GR  = 21;
  localparam int MID = GR / 2;

  typedef struct packed { logic [7:0] col; logic [8:0] row; } hit_t;
  typedef struct packed { logic eom; logic [7:0] col; logic [8:0] row; } stim_t;
  typedef struct packed { logic [1:0] kind; logic [7:0] col; logic [8:0] row; } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_eom = 1'b0, out_ready = 1'b0;
  logic [7:0] in_col = '0;
  logic [8:0] in_row = '0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [7:0] out_col;
  logic [8:0] out_row;

  int total = 0, bad = 0, cyc = 0;
  stim_t stim_q[$];
  item_t exp_q[$];
  bit gm[GC][GR];
  int got_n = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  pixel_cluster_finder u_pixel_cluster_finder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_eom(in_eom),
    .in_col(in_col), .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_col(out_col), .out_row(out_row)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural model of the clustering order, fills stimulus and expected queues
  task automatic model_module(input hit_t hits[$]);
    hit_t pool[$];
    int p = 0;
    foreach (hits[i]) stim_q.push_back({1'b0, hits[i].col, hits[i].row});
    stim_q.push_back({1'b1, 8'd0, 9'd0});
    forever begin
      hit_t refh, h;
      bit g[GC][GR], s[GC][GR];
      int base, n, lc, lr;
      bit changed;
      if (pool.size() == 0) begin
        if (p == hits.size()) begin
          exp_q.push_back({2'd2, 8'd0, 9'd0});
          break;
        end
        refh = hits[p]; p++;
      end else refh = pool.pop_front();
      foreach (g[c, r]) begin g[c][r] = 0; s[c][r] = 0; end
      base = int'(refh.col) & ~1;
      g[refh.col[0]][MID] = 1;
      n = pool.size();
      repeat (n) begin
        h = pool.pop_front();
        lc = int'(h.col) - base; lr = int'(h.row) - int'(refh.row) + MID;
        if (lc >= 0 && lc < GC && lr >= 0 && lr < GR) g[lc][lr] = 1;
        else pool.push_back(h);
      end
      while (p < hits.size() && int'(hits[p].col) < base + GC) begin
        h = hits[p]; p++;
        lc = int'(h.col) - base; lr = int'(h.row) - int'(refh.row) + MID;
        if (lr >= 0 && lr < GR) g[lc][lr] = 1;
        else pool.push_back(h);
      end
      s[0][MID] = g[0][MID];
      s[1][MID] = g[1][MID];
      do begin
        changed = 0;
        for (int c = 0; c < GC; c++)
          for (int r = 0; r < GR; r++)
            if (g[c][r] && !s[c][r])
              for (int dc = -1; dc <= 1; dc++)
                for (int dr = -1; dr <= 1; dr++)
                  if (c+dc >= 0 && c+dc < GC && r+dr >= 0 && r+dr < GR && !s[c][r])
                    if (s[c+dc][r+dr]) begin s[c][r] = 1; changed = 1; end
      end while (changed);
      for (int c = 0; c < GC; c++)
        for (int r = 0; r < GR; r++)
          if (s[c][r]) exp_q.push_back({2'd0, 8'(c), 9'(r)});
      exp_q.push_back({2'd1, refh.col, refh.row});
      for (int c = 0; c < GC; c++)
        for (int r = 0; r < GR; r++)
          if (g[c][r] && !s[c][r]) pool.push_back({8'(base + c), 9'(int'(refh.row) + r - MID)});
    end
  endtask

  task automatic take_word(input item_t w);
    item_t e;
    bit em[GC][GR];
    int mis = 0;
    if (w.kind == 2'd0) begin
      check(w.col < GC && w.row < GR, "R2 hit local range", int'(w.col), GC - 1);
      if (w.col < GC && w.row < GR) begin
        check(!gm[w.col][w.row], "R3 hit repeated in cluster", 1, 0);
        gm[w.col][w.row] = 1;
        got_n++;
      end
    end else if (w.kind == 2'd1) begin
      foreach (em[c, r]) em[c][r] = 0;
      e = '0;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        if (e.kind != 2'd0) break;
        em[e.col][e.row] = 1;
      end
      check(e.kind == 2'd1, "R9 unexpected end-of-cluster word", int'(w.kind), int'(e.kind));
      foreach (em[c, r]) if (em[c][r] != gm[c][r]) mis++;
      check(mis == 0, "R2/R3/R4/R6 cluster cells mismatched", mis, 0);
      check(w.col == e.col && w.row == e.row, "R5/R6 reference coords",
            int'(w.col) * 1000 + int'(w.row), int'(e.col) * 1000 + int'(e.row));
      foreach (gm[c, r]) gm[c][r] = 0;
      got_n = 0;
    end else begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : item_t'('1);
      check(w.kind == 2'd2 && e.kind == 2'd2 && got_n == 0, "R7 end-of-module word",
            int'(w.kind), int'(e.kind));
    end
  endtask

  task automatic add_random_module();
    hit_t hits[$];
    bit used[int];
    int col = 30;
    while (hits.size() < 40) begin
      int row, key;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) col++;
      row = 300 + int'(lf[7:4]) % 12;
      key = col * 512 + row;
      if (!used.exists(key)) begin
        used[key] = 1;
        hits.push_back({8'(col), 9'(row)});
      end
    end
    model_module(hits);
  endtask

  // driver: drives at the falling edge, acceptance decided before the next rising edge
  initial begin
    int k = 0;
    while (rst) @(posedge clk);
    forever begin
      @(negedge clk);
      k++;
      if (stim_q.size() > 0 && (k % 5) != 0) begin
        in_valid = 1'b1;
        {in_eom, in_col, in_row} = stim_q[0];
        #1;
        if (in_ready) void'(stim_q.pop_front());
      end else begin
        in_valid = 1'b0;
        #1;
        check(in_ready == 1'b0, "R10 ready without valid", int'(in_ready), 0);
      end
    end
  end

  // monitor and output ready pattern
  initial begin
    bit held = 0;
    item_t last = '0;
    forever begin
      @(negedge clk);
      out_ready = ((cyc * 7) % 11) < 8;
      #2;
      if (!rst) begin
        if (held)
          check(out_valid && {out_kind, out_col, out_row} == last, "R8 word held under stall",
                int'(out_col), int'(last.col));
        if (out_valid && out_ready) take_word({out_kind, out_col, out_row});
        held = out_valid && !out_ready;
        last = {out_kind, out_col, out_row};
      end
    end
  end

  initial begin
    hit_t m[$];
    // R2 R5 R7: single hit, odd column
    m = '{'{8'd5, 9'd30}};
    model_module(m);
    // R3 R6: diagonal chain from an even reference plus a detached hit
    m = '{'{8'd4, 9'd10}, '{8'd5, 9'd11}, '{8'd6, 9'd12}, '{8'd7, 9'd11}, '{8'd6, 9'd14}};
    model_module(m);
    // R4: horizontal line longer than the grid
    m.delete();
    for (int c = 20; c < 30; c++) m.push_back({8'(c), 9'd100});
    model_module(m);
    // R4 R6: vertical line taller than the grid
    m.delete();
    for (int r = 200; r < 225; r++) m.push_back({8'd40, 9'(r)});
    model_module(m);
    // R6: scattered hits, several recirculations
    m = '{'{8'd60, 9'd20}, '{8'd60, 9'd25}, '{8'd61, 9'd22}, '{8'd62, 9'd30},
          '{8'd63, 9'd21}, '{8'd66, 9'd25}, '{8'd67, 9'd40}, '{8'd67, 9'd26}};
    model_module(m);
    // R2: rows near zero
    m = '{'{8'd70, 9'd0}, '{8'd70, 9'd2}, '{8'd71, 9'd1}, '{8'd72, 9'd0}};
    model_module(m);
    // R7: empty module
    m.delete();
    model_module(m);
    // R2: top edge of both coordinate ranges
    m = '{'{8'd254, 9'd510}, '{8'd255, 9'd511}};
    model_module(m);
    // R9: denser pseudo-random module
    add_random_module();

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 output idle after reset", int'(out_valid), 0);
    check(in_ready == 1'b0, "R1 input not ready after reset", int'(in_ready), 0);

    while (!((stim_q.size() == 0 && exp_q.size() == 0) || cyc > 150000)) @(posedge clk);
    check(cyc <= 150000, "R9 watchdog expired", cyc, 150000);
    repeat (30) @(posedge clk);
    check(exp_q.size() == 0, "R9 expected words left", exp_q.size(), 0);
    check(got_n == 0, "R9 hits without end-of-cluster", got_n, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule